// File: doc/BRIEF.md
# Four-Way Instruction Cache with Exact Recency Replacement

This block is a read-only instruction cache. Each set has four ways. A fetch unit presents a 64-bit byte address, and after a short lookup the cache returns the 32-bit instruction word at that address. Each way holds a valid bit, a tag, a block of one or four words (chosen by a parameter), and a logical timestamp. The timestamp records the reference number of the way's last use.

A lookup that finds the word answers without touching memory. A lookup that misses picks a way in the addressed set. It loads the whole block into that way through a word-wide read port, one word per handshake in ascending address order, and then returns the requested word. Three running counters report references, hits and misses.

Control is a five-state machine:
- IDLE accepts a request.
- PROBE compares all four ways of the set.
- FETCH_ISSUE raises a memory read.
- FETCH_WAIT takes the returned word.
- REPLY presents the answer for one cycle.

The transitions are:
- IDLE goes to PROBE when a request arrives.
- PROBE goes to REPLY on a hit and to FETCH_ISSUE on a miss.
- FETCH_ISSUE always goes to FETCH_WAIT.
- FETCH_WAIT goes back to FETCH_ISSUE while words of the block remain, and to REPLY after the last word.
- REPLY always goes to IDLE.

Top module: `icache_lru_4way`

## Requirements
- R1: The cache has SLOTS/4 sets. The set index is taken from the address bits just above the word-in-block field; with one-word blocks, it sits just above the two byte bits. All remaining upper bits form the tag. With the defaults (32 slots, 4-word blocks), bits [3:2] pick the word, bits [6:4] pick the set, and bits [63:7] are the tag. Accesses to one set never disturb another set.
- R2: After reset every way is invalid, so the first access to any block misses. A way hits only when it is valid and its full tag equals the address tag.
- R3: Every completed lookup adds one to the reference count and one to either the hit or the miss count. The reference count always equals hits plus misses.
- R4: On a miss, the victim is the lowest-numbered invalid way of the set. A valid way is never evicted while an invalid way exists.
- R5: On a miss when all four ways are valid, the way with the smallest timestamp is replaced, with ties going to the lower way. A hit or a fill stamps the way with the new reference count. For the reference order A, B, A, C, D, E in one set, E replaces B.
- R6: A miss issues exactly BLOCK_WORDS memory reads, at the block-aligned base address and then in steps of 4 bytes. The reply carries the word selected by the word-in-block field.
- R7: A hit issues no memory read. It returns the stored word with resp_hit high.
- R8: req_ready is high only in IDLE. resp_valid is high for exactly one cycle per request. req_ready is low while a request is in flight.
- R9: At most one way of a set matches a given address. Blocks whose tags differ only in their top bits coexist and each return their own data.
- R10: Every memory read address has bits [1:0] equal to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Fetch request, taken when req_ready is high |
| req_addr | input | 64 | Byte address of the requested word |
| req_ready | output | 1 | Cache is idle and can take a request |
| resp_valid | output | 1 | One-cycle reply strobe |
| resp_data | output | 32 | Returned instruction word |
| resp_hit | output | 1 | Reply came from a hit |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_rd_addr | output | 64 | Byte address of the memory word to read |
| mem_rd_valid | input | 1 | Memory read data is valid this cycle |
| mem_rd_data | input | 32 | Memory read data |
| ref_count | output | 32 | Completed references |
| hit_count | output | 32 | Completed hits |
| miss_count | output | 32 | Completed misses |

## Verification
The main target is replacement order. The bench fills one set completely, refreshes its oldest way with a hit, and then forces an eviction. A design that ignores the refresh would throw out the refreshed block, and a design that evicts by way number would throw out way 0; in both cases one of the blocks the bench later expects to hit would miss instead. A second set is filled only halfway before a third miss. A cache that runs the recency rule before looking for an invalid way would evict a live block there.

Block fills are checked word by word. A wrong base or word order shows up as a bad read address or wrong returned data. Two blocks whose tags differ only in address bit 32 must both stay resident, which catches a truncated tag compare. A block in a neighbouring set must survive all of this traffic, which catches a wrong set-index slice.

// File: rtl/icache_pkg.sv
package icache_pkg;

    typedef enum logic [2:0] {
        ST_IDLE        = 3'd0,
        ST_PROBE       = 3'd1,
        ST_FETCH_ISSUE = 3'd2,
        ST_FETCH_WAIT  = 3'd3,
        ST_REPLY       = 3'd4
    } icache_state_e;

endpackage

// File: rtl/icache_way_match.sv
module icache_way_match #(
    parameter int WAYS  = 4,
    parameter int TAG_W = 57,
    localparam int IDX_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0]             way_valid,
    input  logic [WAYS-1:0][TAG_W-1:0]  way_tag,
    input  logic [TAG_W-1:0]            probe_tag,
    output logic [WAYS-1:0]             match_vec,
    output logic                        match_any,
    output logic [IDX_W-1:0]            match_idx
);

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign match_vec[w] = way_valid[w] && (way_tag[w] == probe_tag);
    end

    assign match_any = |match_vec;

    always_comb begin
        match_idx = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (match_vec[w]) begin
                match_idx = IDX_W'(w);
            end
        end
    end

endmodule

// File: rtl/icache_victim_pick.sv
module icache_victim_pick #(
    parameter int WAYS = 4,
    parameter int TS_W = 16,
    localparam int IDX_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0]            way_valid,
    input  logic [WAYS-1:0][TS_W-1:0]  way_stamp,
    output logic [IDX_W-1:0]           victim_idx
);

    logic             have_free;
    logic [IDX_W-1:0] free_idx;
    logic [IDX_W-1:0] oldest_idx;
    logic [TS_W-1:0]  oldest_stamp;

    always_comb begin
        have_free = 1'b0;
        free_idx  = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (!have_free && !way_valid[w]) begin
                have_free = 1'b1;
                free_idx  = IDX_W'(w);
            end
        end
        oldest_idx   = '0;
        oldest_stamp = way_stamp[0];
        for (int w = 1; w < WAYS; w++) begin
            if (way_stamp[w] < oldest_stamp) begin
                oldest_stamp = way_stamp[w];
                oldest_idx   = IDX_W'(w);
            end
        end
        victim_idx = have_free ? free_idx : oldest_idx;
    end

endmodule

// File: rtl/icache_lru_4way.sv
module icache_lru_4way #(
    parameter int ADDR_W      = 64,
    parameter int DATA_W      = 32,
    parameter int SLOTS       = 32,
    parameter int WAYS        = 4,
    parameter int BLOCK_WORDS = 4,
    parameter int TS_W        = 16,
    parameter int CNT_W       = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              req_ready,
    output logic              resp_valid,
    output logic [DATA_W-1:0] resp_data,
    output logic              resp_hit,
    output logic              mem_rd_en,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic              mem_rd_valid,
    input  logic [DATA_W-1:0] mem_rd_data,
    output logic [CNT_W-1:0]  ref_count,
    output logic [CNT_W-1:0]  hit_count,
    output logic [CNT_W-1:0]  miss_count
);
    import icache_pkg::*;

    localparam int SETS      = SLOTS / WAYS;
    localparam int SET_W     = $clog2(SETS);
    localparam int IDX_W     = $clog2(WAYS);
    localparam int WOFF_BITS = $clog2(BLOCK_WORDS);
    localparam int WOFF_W    = (WOFF_BITS > 0) ? WOFF_BITS : 1;
    localparam int SET_LSB   = 2 + WOFF_BITS;
    localparam int TAG_W     = ADDR_W - SET_LSB - SET_W;
    localparam logic [ADDR_W-1:0] BLK_MASK = ~ADDR_W'(BLOCK_WORDS * 4 - 1);
    localparam logic [WOFF_W-1:0] LAST_WORD = WOFF_W'(BLOCK_WORDS - 1);

    icache_state_e state_q, state_d;

    logic [SETS-1:0][WAYS-1:0]                          valid_q;
    logic [SETS-1:0][WAYS-1:0][TAG_W-1:0]               tag_q;
    logic [SETS-1:0][WAYS-1:0][TS_W-1:0]                stamp_q;
    logic [SETS-1:0][WAYS-1:0][BLOCK_WORDS-1:0][DATA_W-1:0] data_q;

    logic [ADDR_W-1:0] addr_q;
    logic [IDX_W-1:0]  victim_q;
    logic [WOFF_W-1:0] fill_q;
    logic [DATA_W-1:0] rdata_q;
    logic              rhit_q;
    logic [CNT_W-1:0]  ref_q, hit_q, miss_q;

    logic [SET_W-1:0]  set_sel;
    logic [TAG_W-1:0]  tag_sel;
    logic [WOFF_W-1:0] woff_sel;
    logic [WAYS-1:0]   hit_vec;
    logic              hit_any;
    logic [IDX_W-1:0]  hit_idx;
    logic [IDX_W-1:0]  victim_idx;
    logic              fill_last;
    logic [TS_W-1:0]   new_stamp;
    logic              unused_bits;

    assign set_sel     = addr_q[SET_LSB +: SET_W];
    assign tag_sel     = addr_q[ADDR_W-1 -: TAG_W];
    assign woff_sel    = (BLOCK_WORDS > 1) ? addr_q[2 +: WOFF_W] : '0;
    assign fill_last   = (fill_q == LAST_WORD);
    assign new_stamp   = TS_W'(ref_q + CNT_W'(1));
    assign unused_bits = ^addr_q[1:0];

    icache_way_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_match (
        .way_valid (valid_q[set_sel]),
        .way_tag   (tag_q[set_sel]),
        .probe_tag (tag_sel),
        .match_vec (hit_vec),
        .match_any (hit_any),
        .match_idx (hit_idx)
    );

    icache_victim_pick #(.WAYS(WAYS), .TS_W(TS_W)) u_victim (
        .way_valid  (valid_q[set_sel]),
        .way_stamp  (stamp_q[set_sel]),
        .victim_idx (victim_idx)
    );

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:        if (req_valid) state_d = ST_PROBE;
            ST_PROBE:       state_d = hit_any ? ST_REPLY : ST_FETCH_ISSUE;
            ST_FETCH_ISSUE: state_d = ST_FETCH_WAIT;
            ST_FETCH_WAIT:  if (mem_rd_valid) state_d = fill_last ? ST_REPLY : ST_FETCH_ISSUE;
            ST_REPLY:       state_d = ST_IDLE;
            default:        state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        req_ready   = (state_q == ST_IDLE);
        resp_valid  = (state_q == ST_REPLY);
        mem_rd_en   = (state_q == ST_FETCH_ISSUE);
        mem_rd_addr = (addr_q & BLK_MASK) + ADDR_W'({fill_q, 2'b00});
        resp_data   = rdata_q;
        resp_hit    = rhit_q;
        ref_count   = ref_q;
        hit_count   = hit_q;
        miss_count  = miss_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q  <= '0;
            stamp_q  <= '0;
            addr_q   <= '0;
            victim_q <= '0;
            fill_q   <= '0;
            rdata_q  <= '0;
            rhit_q   <= 1'b0;
            ref_q    <= '0;
            hit_q    <= '0;
            miss_q   <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (req_valid) addr_q <= req_addr;
                end
                ST_PROBE: begin
                    if (hit_any) begin
                        stamp_q[set_sel][hit_idx] <= new_stamp;
                        rdata_q <= data_q[set_sel][hit_idx][woff_sel];
                        rhit_q  <= 1'b1;
                        ref_q   <= ref_q + CNT_W'(1);
                        hit_q   <= hit_q + CNT_W'(1);
                    end else begin
                        victim_q <= victim_idx;
                        fill_q   <= '0;
                        rhit_q   <= 1'b0;
                    end
                end
                ST_FETCH_WAIT: begin
                    if (mem_rd_valid) begin
                        data_q[set_sel][victim_q][fill_q] <= mem_rd_data;
                        if (fill_q == woff_sel) rdata_q <= mem_rd_data;
                        if (fill_last) begin
                            valid_q[set_sel][victim_q] <= 1'b1;
                            tag_q[set_sel][victim_q]   <= tag_sel;
                            stamp_q[set_sel][victim_q] <= new_stamp;
                            ref_q  <= ref_q + CNT_W'(1);
                            miss_q <= miss_q + CNT_W'(1);
                        end else begin
                            fill_q <= fill_q + WOFF_W'(1);
                        end
                    end
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/icache_lru_4way_checker.sv
module icache_lru_4way_checker #(
    parameter int ADDR_W = 64,
    parameter int WAYS   = 4,
    parameter int CNT_W  = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              req_ready,
    input logic              resp_valid,
    input logic              resp_hit,
    input logic              mem_rd_en,
    input logic [ADDR_W-1:0] mem_rd_addr,
    input logic [CNT_W-1:0]  ref_count,
    input logic [CNT_W-1:0]  hit_count,
    input logic [CNT_W-1:0]  miss_count,
    input logic [WAYS-1:0]   hit_vec
);

    AST_REF_BALANCE: assert property (@(posedge clk) disable iff (rst)
        ref_count == hit_count + miss_count); // R3

    AST_REF_STEP: assert property (@(posedge clk) disable iff (rst)
        resp_valid |-> ref_count == $past(ref_count) + CNT_W'(1)); // R3

    AST_MISS_STEP: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && !resp_hit) |-> miss_count == $past(miss_count) + CNT_W'(1)); // R2

    AST_HIT_STEP: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && resp_hit) |-> hit_count == $past(hit_count) + CNT_W'(1)); // R7

    AST_SINGLE_MATCH: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hit_vec)); // R9

    AST_REPLY_PULSE: assert property (@(posedge clk) disable iff (rst)
        resp_valid |=> !resp_valid); // R8

    AST_BUSY_REPLY: assert property (@(posedge clk) disable iff (rst)
        resp_valid |-> !req_ready); // R8

    AST_WORD_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        mem_rd_en |-> mem_rd_addr[1:0] == 2'b00); // R10

endmodule

bind icache_lru_4way icache_lru_4way_checker #(
    .ADDR_W (ADDR_W),
    .WAYS   (WAYS),
    .CNT_W  (CNT_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .req_ready   (req_ready),
    .resp_valid  (resp_valid),
    .resp_hit    (resp_hit),
    .mem_rd_en   (mem_rd_en),
    .mem_rd_addr (mem_rd_addr),
    .ref_count   (ref_count),
    .hit_count   (hit_count),
    .miss_count  (miss_count),
    .hit_vec     (hit_vec)
);

// File: tb/icache_lru_4way_bench.sv
`timescale 1ns/1ps
module icache_lru_4way_bench;

    localparam int BW = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [63:0] req_addr = '0;
    logic        req_ready, resp_valid, resp_hit, mem_rd_en;
    logic [31:0] resp_data;
    logic [63:0] mem_rd_addr;
    logic        mem_rd_valid;
    logic [31:0] mem_rd_data;
    logic [31:0] ref_count, hit_count, miss_count;

    int total = 0;
    int bad   = 0;
    int rd_count = 0;
    logic [63:0] rd_log [4];
    int exp_refs = 0, exp_hits = 0, exp_miss = 0;

    always #2.5 clk = ~clk;

    icache_lru_4way u_icache_lru_4way (
        .clk (clk), .rst (rst),
        .req_valid (req_valid), .req_addr (req_addr), .req_ready (req_ready),
        .resp_valid (resp_valid), .resp_data (resp_data), .resp_hit (resp_hit),
        .mem_rd_en (mem_rd_en), .mem_rd_addr (mem_rd_addr),
        .mem_rd_valid (mem_rd_valid), .mem_rd_data (mem_rd_data),
        .ref_count (ref_count), .hit_count (hit_count), .miss_count (miss_count)
    );

    function automatic logic [31:0] word_at(input logic [63:0] a);
        return a[31:0] ^ 32'hC3A5_0000 ^ a[63:32];
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            mem_rd_valid <= 1'b0;
            mem_rd_data  <= '0;
        end else begin
            mem_rd_valid <= mem_rd_en;
            mem_rd_data  <= word_at(mem_rd_addr);
            if (mem_rd_en) begin
                rd_log[rd_count % 4] <= mem_rd_addr;
                rd_count <= rd_count + 1;
            end
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic access(input logic [63:0] a, input bit exp_hit, input string req);
        int reads0;
        int cyc;
        logic [63:0] base;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        reads0    = rd_count;
        req_valid = 1'b1;
        req_addr  = a;
        @(negedge clk);
        req_valid = 1'b0;
        check(req_ready == 1'b0, "R8", "ready low while busy", 64'(req_ready), 64'd0);
        cyc = 0;
        while (!resp_valid && cyc < 100) begin
            @(negedge clk);
            cyc++;
        end
        check(resp_valid == 1'b1, "R8", "reply strobe", 64'(resp_valid), 64'd1);
        check(resp_data == word_at(a), req, "returned word", 64'(resp_data), 64'(word_at(a)));
        check(resp_hit == exp_hit, req, "hit flag", 64'(resp_hit), 64'(exp_hit));
        exp_refs++;
        if (exp_hit) begin
            exp_hits++;
            check(rd_count == reads0, "R7", "no memory read on hit", 64'(rd_count - reads0), 64'd0);
        end else begin
            exp_miss++;
            check(rd_count - reads0 == BW, "R6", "reads per fill", 64'(rd_count - reads0), 64'(BW));
            base = a & ~64'hF;
            for (int k = 0; k < BW; k++) begin
                check(rd_log[k] == base + 64'(4 * k), "R6", "fill address order", rd_log[k], base + 64'(4 * k));
                check(rd_log[k][1:0] == 2'b00, "R10", "aligned read", 64'(rd_log[k][1:0]), 64'd0);
            end
        end
        @(negedge clk);
        check(resp_valid == 1'b0, "R8", "reply lasts one cycle", 64'(resp_valid), 64'd0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(req_ready == 1'b1, "R8", "ready after reset", 64'(req_ready), 64'd1);
        check(resp_valid == 1'b0, "R8", "no reply after reset", 64'(resp_valid), 64'd0);
        check(ref_count == 0, "R3", "refs after reset", 64'(ref_count), 64'd0);
        check(hit_count == 0 && miss_count == 0, "R3", "hits/misses after reset",
              64'(hit_count + miss_count), 64'd0);
    endtask

    task automatic t_block_fill();
        access(64'h1008, 1'b0, "R2");
        access(64'h1000, 1'b1, "R7");
        access(64'h1004, 1'b1, "R7");
        access(64'h100C, 1'b1, "R6");
    endtask

    // set 1 addresses: stride 0x80
    task automatic t_recency();
        access(64'h0010, 1'b0, "R5");
        access(64'h0090, 1'b0, "R5");
        access(64'h0110, 1'b0, "R5");
        access(64'h0190, 1'b0, "R5");
        access(64'h0014, 1'b1, "R5");
        access(64'h0210, 1'b0, "R5");
        access(64'h0018, 1'b1, "R5");
        access(64'h0114, 1'b1, "R5");
        access(64'h0194, 1'b1, "R5");
        access(64'h0214, 1'b1, "R5");
        access(64'h0090, 1'b0, "R5");
        access(64'h1004, 1'b1, "R1");
    endtask

    // set 2 half full: next miss must take a free way
    task automatic t_free_first();
        access(64'h0020, 1'b0, "R4");
        access(64'h00A0, 1'b0, "R4");
        access(64'h0120, 1'b0, "R4");
        access(64'h0024, 1'b1, "R4");
        access(64'h00A4, 1'b1, "R4");
        access(64'h0124, 1'b1, "R4");
    endtask

    task automatic t_high_tag();
        access(64'h0000_0000_0000_0030, 1'b0, "R9");
        access(64'h0000_0001_0000_0030, 1'b0, "R9");
        access(64'h0000_0000_0000_0034, 1'b1, "R9");
        access(64'h0000_0001_0000_0038, 1'b1, "R1");
    endtask

    task automatic t_counters();
        @(negedge clk);
        check(ref_count == exp_refs, "R3", "reference count", 64'(ref_count), 64'(exp_refs));
        check(hit_count == exp_hits, "R3", "hit count", 64'(hit_count), 64'(exp_hits));
        check(miss_count == exp_miss, "R3", "miss count", 64'(miss_count), 64'(exp_miss));
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_block_fill();
        t_recency();
        t_free_first();
        t_high_tag();
        t_counters();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule